// File: doc/BRIEF.md
# Signed Q32.32 Fixed-Point Multiplier

This block multiplies two signed 64-bit fixed-point numbers that each carry 32 integer bits and 32 fraction bits. The result has the same format. Each operand is split into a high and a low 32-bit half. A single shared 32x32 unsigned multiplier then produces the four half-word partial products, one per cycle. Each partial product is shifted into place and summed into a 128-bit unsigned accumulator.

After the last partial product, one correction cycle makes the sum a two's-complement product. For each operand whose sign bit is set, the other operand is subtracted from the upper 64 bits of the sum. The result is bits 95 down to 32 of the corrected product. Integer bits above that window are dropped, so the result wraps on overflow. Fraction bits below the window are cut off without rounding.

The caller presents both operands with a one-cycle start pulse. It waits for a one-cycle done pulse, after which the result output holds its value until the next product completes.

Top module: `fxq_mul_top`

## Requirements
- R1: `result` equals bits 95..32 of the exact 128-bit two's-complement product of `op_a` and `op_b`, each read as a signed 64-bit integer.
- R2: 1.0 times 1.0 (both operands 0x0000_0001_0000_0000) gives 0x0000_0001_0000_0000.
- R3: A negative operand times a positive operand gives the correctly signed result; -1.5 times 2.0 gives 0xFFFF_FFFD_0000_0000.
- R4: Two negative operands give a positive result; -0.5 times -4.0 gives 0x0000_0002_0000_0000.
- R5: Fraction bits below 2^-32 are truncated toward minus infinity. 2^-32 times 0.5 gives 0, and -2^-32 times 0.5 gives 0xFFFF_FFFF_FFFF_FFFF.
- R6: Product bits above bit 95 are discarded; 65536.0 times 65536.0 gives 0.
- R7: Carries out of the sum of the two cross products reach the upper half of the window; 0x0000_0001_FFFF_FFFF squared gives 0x0000_0003_FFFF_FFFC.
- R8: `done` is high for exactly one cycle, five clock edges after the edge that accepts `start`.
- R9: A `start` pulse that arrives while a product is in progress is ignored: it produces no extra `done` and does not change the result being computed.
- R10: While reset is held and after it is released, `done` is 0 and `result` is 0 until the first product completes.
- R11: `result` changes only at the edge that raises `done`, and it holds its value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepts both operands when the unit is idle |
| op_a | input | 64 | Multiplicand, signed Q32.32 |
| op_b | input | 64 | Multiplier, signed Q32.32 |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 64 | Registered signed Q32.32 product |

## Verification
The bench targets the sign correction with mixed-sign and double-negative operands. If a correction term is missing or subtracted from the wrong half, these cases return a value that is off by a whole operand in the upper half.

A pair of operands chosen so that the two cross products carry across bit 64 exposes a datapath that loses that carry. Such a design returns an upper half that is one too small.

Two of the cases fall apart in specific faulty designs:
- An operand of minus one least-significant bit times one half catches a design that rounds toward zero rather than flooring.
- Squaring 65536.0 catches a design that keeps the wrong window of the product.

A second `start` sent mid-operation catches a sequencer that restarts or emits two `done` pulses.

// File: rtl/fxq_mul_pkg.sv
package fxq_mul_pkg;

  // Sequencer steps: idle, four partial products, one sign-correction cycle.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LL   = 3'd1,
    ST_LH   = 3'd2,
    ST_HL   = 3'd3,
    ST_HH   = 3'd4,
    ST_FIX  = 3'd5
  } mul_step_e;

  localparam int unsigned BUSY_STEPS = 5;

endpackage

// File: rtl/fxq_mul_ctrl.sv
module fxq_mul_ctrl
  import fxq_mul_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output logic      load,
  output mul_step_e step
);

  mul_step_e step_q, step_d;

  assign load = start && (step_q == ST_IDLE);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE: if (start) step_d = ST_LL;
      ST_LL:   step_d = ST_LH;
      ST_LH:   step_d = ST_HL;
      ST_HL:   step_d = ST_HH;
      ST_HH:   step_d = ST_FIX;
      ST_FIX:  step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  assign step = step_q;

  // R9
  seq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_LL) |=> (step_q == ST_LH));

endmodule

// File: rtl/fxq_mul_pp.sv
module fxq_mul_pp
  import fxq_mul_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  mul_step_e               step,
  input  logic [2*HALF_W-1:0]     a_q,
  input  logic [2*HALF_W-1:0]     b_q,
  output logic [4*HALF_W-1:0]     term
);

  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned ACC_W  = 2 * WORD_W;

  logic [HALF_W-1:0] a_half [2];
  logic [HALF_W-1:0] b_half [2];

  for (genvar g = 0; g < 2; g++) begin : g_split
    assign a_half[g] = a_q[g*HALF_W +: HALF_W];
    assign b_half[g] = b_q[g*HALF_W +: HALF_W];
  end

  logic [HALF_W-1:0] mx, my;
  logic [1:0]        place;  // 0: no shift, 1: one half, 2: two halves

  always_comb begin
    mx    = '0;
    my    = '0;
    place = 2'd0;
    unique case (step)
      ST_LL: begin mx = a_half[0]; my = b_half[0]; place = 2'd0; end
      ST_LH: begin mx = a_half[0]; my = b_half[1]; place = 2'd1; end
      ST_HL: begin mx = a_half[1]; my = b_half[0]; place = 2'd1; end
      ST_HH: begin mx = a_half[1]; my = b_half[1]; place = 2'd2; end
      default: begin mx = '0; my = '0; place = 2'd0; end
    endcase
  end

  // Single shared unsigned half-word multiplier.
  logic [WORD_W-1:0] prod;
  assign prod = WORD_W'(mx) * WORD_W'(my);

  always_comb begin
    unique case (place)
      2'd1:    term = ACC_W'(prod) << HALF_W;
      2'd2:    term = ACC_W'(prod) << WORD_W;
      default: term = ACC_W'(prod);
    endcase
  end

endmodule

// File: rtl/fxq_mul_acc.sv
module fxq_mul_acc
  import fxq_mul_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  mul_step_e           step,
  input  logic [2*HALF_W-1:0] a_q,
  input  logic [2*HALF_W-1:0] b_q,
  input  logic [4*HALF_W-1:0] term,
  output logic                done,
  output logic [2*HALF_W-1:0] result
);

  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned ACC_W  = 2 * WORD_W;

  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] corr, fixed_hi;
  logic              done_q;
  logic [WORD_W-1:0] res_q;

  // Two's-complement correction of the upper half (mod 2^WORD_W).
  always_comb begin
    corr = '0;
    if (a_q[WORD_W-1]) corr = corr + b_q;
    if (b_q[WORD_W-1]) corr = corr + a_q;
    fixed_hi = acc_q[ACC_W-1:WORD_W] - corr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        acc_q <= '0;
      end else if (step == ST_LL || step == ST_LH ||
                   step == ST_HL || step == ST_HH) begin
        acc_q <= acc_q + term;
      end else if (step == ST_FIX) begin
        res_q  <= {fixed_hi[HALF_W-1:0], acc_q[WORD_W-1:HALF_W]};
        done_q <= 1'b1;
      end
    end
  end

  assign done   = done_q;
  assign result = res_q;

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(step) == ST_FIX));

endmodule

// File: rtl/fxq_mul_top.sv
module fxq_mul_top
  import fxq_mul_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              done,
  output logic [WORD_W-1:0] result
);

  localparam int unsigned ACC_W = 2 * WORD_W;

  logic              load;
  mul_step_e         step;
  logic [WORD_W-1:0] a_q, b_q;
  logic [ACC_W-1:0]  term;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  fxq_mul_ctrl i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step)
  );

  fxq_mul_pp #(.HALF_W(HALF_W)) i_pp (
    .step (step),
    .a_q  (a_q),
    .b_q  (b_q),
    .term (term)
  );

  fxq_mul_acc #(.HALF_W(HALF_W)) i_acc (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .a_q    (a_q),
    .b_q    (b_q),
    .term   (term),
    .done   (done),
    .result (result)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R9
  opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done));

endmodule

// File: tb/test_fxq_mul_top.sv
module test_fxq_mul_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        done;
  logic [63:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fxq_mul_top i_fxq_mul_top (
    .clk(clk), .rst(rst), .start(start),
    .op_a(op_a), .op_b(op_b), .done(done), .result(result)
  );

  function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] wa, wb, p;
    wa = {{64{a[63]}}, a};
    wb = {{64{b[63]}}, b};
    p  = wa * wb;
    return p[95:32];
  endfunction

  // Cycle-by-cycle reference model
  int          m_cnt;
  logic        m_done;
  logic [63:0] m_res, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_done <= 1'b0; m_res <= '0; m_pend <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_cnt == 0) begin
        if (start) begin
          m_pend <= ref_mul(op_a, op_b);
          m_cnt  <= 5;
        end
      end else begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_done <= 1'b1;
          m_res  <= m_pend;
        end
      end
    end
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge (R1 result, R8 done, R10, R11)
  always @(negedge clk) begin
    if (!finished) begin
      check64("R1/R11 result vs model", result, m_res);
      check64("R8/R10 done vs model", {63'b0, done}, {63'b0, m_done});
    end
  end

  task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp);
    int lat;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    check64({tag, " value"}, result, exp);
    check64("R8 latency", 64'(lat), 64'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check64("R10 done in reset", {63'b0, done}, 64'd0);
    check64("R10 result in reset", result, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check64("R10 result after reset", result, 64'd0);

    run_op("R2 one times one", 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000,
           64'h0000_0001_0000_0000);
    run_op("R3 neg times pos", 64'hFFFF_FFFE_8000_0000, 64'h0000_0002_0000_0000,
           64'hFFFF_FFFD_0000_0000);
    run_op("R3 pos times neg", 64'h0000_0002_0000_0000, 64'hFFFF_FFFE_8000_0000,
           64'hFFFF_FFFD_0000_0000);
    run_op("R4 neg times neg", 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFC_0000_0000,
           64'h0000_0002_0000_0000);
    run_op("R5 tiny positive", 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000,
           64'h0000_0000_0000_0000);
    run_op("R5 tiny negative", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
           64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R6 wrap", 64'h0001_0000_0000_0000, 64'h0001_0000_0000_0000,
           64'h0000_0000_0000_0000);
    run_op("R7 cross carry", 64'h0000_0001_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF,
           64'h0000_0003_FFFF_FFFC);
    run_op("R1 mixed", 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_1234_5678,
           ref_mul(64'h8000_0000_0000_0001, 64'h7FFF_FFFF_1234_5678));

    // R11 result holds while idle
    repeat (8) @(negedge clk);
    check64("R11 hold while idle", result,
            ref_mul(64'h8000_0000_0000_0001, 64'h7FFF_FFFF_1234_5678));

    // R9 start while busy is ignored
    begin
      int dones;
      dones = 0;
      @(negedge clk);
      start = 1'b1; op_a = 64'h0000_0001_0000_0000; op_b = 64'h0000_0001_8000_0000;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; op_a = 64'h0000_0003_0000_0000; op_b = 64'h0000_0003_0000_0000;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (done) dones++;
        @(negedge clk);
      end
      check64("R9 single done", 64'(dones), 64'd1);
      check64("R9 first operands kept", result, 64'h0000_0001_8000_0000);
    end

    // Back-to-back: start in the done cycle is accepted
    @(negedge clk);
    start = 1'b1; op_a = 64'h0000_0002_0000_0000; op_b = 64'h0000_0002_0000_0000;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; op_a = 64'hFFFF_FFFF_0000_0000; op_b = 64'h0000_0005_0000_0000;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check64("R1 back to back", result, 64'hFFFF_FFFB_0000_0000);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule